// File: doc/BRIEF.md
# Speculative Translation Load-Store Queue

This block is an in-order queue of memory operations in which an entry can send its memory request before its address translation is confirmed. An entry allocated with a predicted physical address sends its memory request in the same cycle and is marked speculative. An entry allocated with an exact translation is never speculative. Data that comes back for a speculative entry is kept, but the entry cannot commit until a verification message confirms the address.

When the walker's verification arrives, the queue compares the confirmed address with the stored prediction. There are three outcomes:
- If the addresses match, the speculative mark is cleared.
- If they differ and the data has already come back, the queue raises a flush request at that entry. It then discards that entry and every younger one and rewinds its tail to that entry.
- If they differ and the data has not yet come back, the queue corrects the stored address and sends a second memory request under a new tag. It drops the response to the first request when that response arrives.

Every memory request carries an entry index and a generation tag. A response whose tag is no longer current is ignored. Entries retire from the head in allocation order. Register checkpointing and the pipeline rollback itself belong to the surrounding core.

Top module: `spec_xlate_lsq`

## Requirements
- R1: An allocation writes the entry at the tail index. In the same cycle it drives a memory request with the given address, that index and a generation tag one above the slot's previous tag, modulo 2^GEN_W. The slot's tag starts at 0 after reset. Indices advance by one and wrap from DEPTH-1 to 0. alloc_ready_o is low while DEPTH entries are held.
- R2: An entry allocated with alloc_spec_i = 0 becomes commit-ready once a response with its current tag arrives. No verification is needed.
- R3: A speculative entry whose data has arrived stays not ready (its ready_vec_o bit stays 0) until a matching verification.
- R4: A verification whose address equals the stored prediction clears the speculative mark. The entry is ready once its data is present, whichever of data and verification came first.
- R5: A mismatching verification for a speculative entry that already holds data pulses flush_valid_o one cycle later, with flush_idx_o set to that entry. That entry and all younger entries are removed, and the next allocation reuses that index. No reissue is made.
- R6: A mismatching verification for a speculative entry without data raises no flush. One cycle later it pulses reis_valid_o with the corrected address, the index, and the slot tag plus one. The entry later commits with the corrected address.
- R7: A response whose tag differs from the slot's current tag, or which targets an empty slot, is dropped and leaves the entry without data.
- R8: cmt_valid_o shows only the head entry, when it is ready. Younger ready entries wait, and entries retire in allocation order when cmt_take_i is high.
- R9: A verification for a non-speculative or empty entry changes nothing: no flush, no reissue, no change to the committed address.
- R10: After reset the queue is empty, alloc_ready_o is high, and cmt_valid_o, flush_valid_o and reis_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Allocate a new entry at the tail |
| alloc_spec_i | input | 1 | 1 = address is a prediction, 0 = exact |
| alloc_pa_i | input | PA_W | Physical address for the new entry |
| alloc_ready_o | output | 1 | Queue can accept an allocation |
| mreq_valid_o | output | 1 | First memory request issued |
| mreq_idx_o | output | IW | Entry index of the request |
| mreq_gen_o | output | GEN_W | Generation tag of the request |
| mreq_pa_o | output | PA_W | Request address |
| reis_valid_o | output | 1 | Corrected-address reissue |
| reis_idx_o | output | IW | Entry index of the reissue |
| reis_gen_o | output | GEN_W | New generation tag |
| reis_pa_o | output | PA_W | Corrected address |
| resp_valid_i | input | 1 | Memory response valid |
| resp_idx_i | input | IW | Entry index of the response |
| resp_gen_i | input | GEN_W | Tag of the response |
| resp_data_i | input | DATA_W | Response data |
| ver_valid_i | input | 1 | Verification from the walker |
| ver_idx_i | input | IW | Entry being verified |
| ver_pa_i | input | PA_W | Confirmed physical address |
| ready_vec_o | output | DEPTH | Per-entry commit-ready flags |
| cmt_valid_o | output | 1 | Head entry is ready to retire |
| cmt_idx_o | output | IW | Head index |
| cmt_pa_o | output | PA_W | Head physical address |
| cmt_data_o | output | DATA_W | Head data |
| cmt_take_i | input | 1 | Retire the head entry |
| flush_valid_o | output | 1 | Pipeline flush request pulse |
| flush_idx_o | output | IW | Oldest entry to flush |

## Verification
A wrong speculative mark shows at the ports as an entry that commits before verification or never commits. That appears in ready_vec_o and cmt_valid_o in the cycle right after the data or verification edge. A stale generation tag lets wrong-address data reach cmt_data_o as soon as that entry reaches the head. A bad ring distance in the flush path shows up within one allocation, as a wrong mreq_idx_o or as surviving younger entries on the commit port. The sweeps cover every ordering of data and verification, in each slot position across wrap-around.

// File: rtl/stlq_pkg.sv
package stlq_pkg;

  typedef enum logic [1:0] {
    VO_NONE    = 2'd0,
    VO_CONFIRM = 2'd1,
    VO_REISSUE = 2'd2,
    VO_FLUSH   = 2'd3
  } ver_out_e;

  function automatic int ring_next(int p, int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // distance walking forward from 'from_p' to 'to_p' on a ring of 'depth'
  function automatic int ring_dist(int from_p, int to_p, int depth);
    return (to_p >= from_p) ? (to_p - from_p) : (to_p + depth - from_p);
  endfunction

  function automatic ver_out_e classify(logic hit, logic spec, logic have, logic same);
    if (!(hit && spec)) return VO_NONE;
    if (same)           return VO_CONFIRM;
    if (have)           return VO_FLUSH;
    return VO_REISSUE;
  endfunction

endpackage

// File: rtl/stlq_entry.sv
module stlq_entry #(
  parameter int PA_W   = 36,
  parameter int DATA_W = 64,
  parameter int GEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              alloc_spec_i,
  input  logic [PA_W-1:0]   alloc_pa_i,
  input  logic              kill_i,
  input  logic              pop_i,
  input  logic              confirm_i,
  input  logic              fix_i,
  input  logic [PA_W-1:0]   fix_pa_i,
  input  logic              resp_i,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              valid_o,
  output logic              spec_o,
  output logic              have_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [DATA_W-1:0] data_o,
  output logic [GEN_W-1:0]  gen_o
);

  logic              valid_q, spec_q, have_q;
  logic [PA_W-1:0]   pa_q;
  logic [DATA_W-1:0] data_q;
  logic [GEN_W-1:0]  gen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      spec_q  <= 1'b0;
      have_q  <= 1'b0;
      pa_q    <= '0;
      data_q  <= '0;
      gen_q   <= '0;
    end else if (kill_i || pop_i) begin
      valid_q <= 1'b0;
      spec_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      spec_q  <= alloc_spec_i;
      have_q  <= 1'b0;
      pa_q    <= alloc_pa_i;
      gen_q   <= gen_q + GEN_W'(1);
    end else begin
      if (confirm_i) spec_q <= 1'b0;
      if (fix_i) begin
        spec_q <= 1'b0;
        pa_q   <= fix_pa_i;
        gen_q  <= gen_q + GEN_W'(1);
      end
      if (resp_i) begin
        have_q <= 1'b1;
        data_q <= resp_data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign spec_o  = spec_q;
  assign have_o  = have_q;
  assign pa_o    = pa_q;
  assign data_o  = data_q;
  assign gen_o   = gen_q;

  // R3: speculation can only be raised by an allocation
  assert_spec_only_from_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_q) |-> $past(alloc_i))
    else $error("speculative mark set without allocation");

  // R7: held data is never dropped except by retire, flush or reuse
  assert_data_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !kill_i && !pop_i && !alloc_i) |=> have_q)
    else $error("entry data lost");

endmodule

// File: rtl/stlq_ptrs.sv
module stlq_ptrs
  import stlq_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [IW-1:0] flush_idx_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic          full_o
);

  logic [IW-1:0] head_q, tail_q, head_d, tail_d;
  logic [CW-1:0] count_q, count_d;

  always_comb begin
    head_d = pop_i ? IW'(ring_next(int'(head_q), DEPTH)) : head_q;
    if (flush_i) begin
      tail_d  = flush_idx_i;
      count_d = CW'(ring_dist(int'(head_q), int'(flush_idx_i), DEPTH) - (pop_i ? 1 : 0));
    end else begin
      tail_d  = alloc_i ? IW'(ring_next(int'(tail_q), DEPTH)) : tail_q;
      count_d = CW'(int'(count_q) + (alloc_i ? 1 : 0) - (pop_i ? 1 : 0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (count_q == CW'(DEPTH));

  // R1: occupancy stays within depth and agrees with the pointer gap
  assert_count_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= CW'(DEPTH)) &&
    ((int'(count_q) % DEPTH) == ring_dist(int'(head_q), int'(tail_q), DEPTH)))
    else $error("occupancy and pointers disagree");

endmodule

// File: rtl/stlq_verify.sv
module stlq_verify
  import stlq_pkg::*;
#(
  parameter int IW    = 6,
  parameter int PA_W  = 36,
  parameter int GEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ver_valid_i,
  input  logic [IW-1:0]    ver_idx_i,
  input  logic [PA_W-1:0]  ver_pa_i,
  input  logic             sel_valid_i,
  input  logic             sel_spec_i,
  input  logic             sel_have_i,
  input  logic [PA_W-1:0]  sel_pa_i,
  input  logic [GEN_W-1:0] sel_gen_i,
  output ver_out_e         outcome_o,
  output logic             flush_valid_o,
  output logic [IW-1:0]    flush_idx_o,
  output logic             reis_valid_o,
  output logic [IW-1:0]    reis_idx_o,
  output logic [PA_W-1:0]  reis_pa_o,
  output logic [GEN_W-1:0] reis_gen_o
);

  assign outcome_o = classify(ver_valid_i && sel_valid_i, sel_spec_i, sel_have_i,
                              ver_pa_i == sel_pa_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_valid_o <= 1'b0;
      flush_idx_o   <= '0;
      reis_valid_o  <= 1'b0;
      reis_idx_o    <= '0;
      reis_pa_o     <= '0;
      reis_gen_o    <= '0;
    end else begin
      flush_valid_o <= (outcome_o == VO_FLUSH);
      reis_valid_o  <= (outcome_o == VO_REISSUE);
      if (outcome_o == VO_FLUSH) flush_idx_o <= ver_idx_i;
      if (outcome_o == VO_REISSUE) begin
        reis_idx_o <= ver_idx_i;
        reis_pa_o  <= ver_pa_i;
        reis_gen_o <= sel_gen_i + GEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/spec_xlate_lsq.sv
module spec_xlate_lsq
  import stlq_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int PA_W   = 36,
  parameter int DATA_W = 64,
  parameter int GEN_W  = 2,
  parameter int IW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid_i,
  input  logic              alloc_spec_i,
  input  logic [PA_W-1:0]   alloc_pa_i,
  output logic              alloc_ready_o,
  output logic              mreq_valid_o,
  output logic [IW-1:0]     mreq_idx_o,
  output logic [GEN_W-1:0]  mreq_gen_o,
  output logic [PA_W-1:0]   mreq_pa_o,
  output logic              reis_valid_o,
  output logic [IW-1:0]     reis_idx_o,
  output logic [GEN_W-1:0]  reis_gen_o,
  output logic [PA_W-1:0]   reis_pa_o,
  input  logic              resp_valid_i,
  input  logic [IW-1:0]     resp_idx_i,
  input  logic [GEN_W-1:0]  resp_gen_i,
  input  logic [DATA_W-1:0] resp_data_i,
  input  logic              ver_valid_i,
  input  logic [IW-1:0]     ver_idx_i,
  input  logic [PA_W-1:0]   ver_pa_i,
  output logic [DEPTH-1:0]  ready_vec_o,
  output logic              cmt_valid_o,
  output logic [IW-1:0]     cmt_idx_o,
  output logic [PA_W-1:0]   cmt_pa_o,
  output logic [DATA_W-1:0] cmt_data_o,
  input  logic              cmt_take_i,
  output logic              flush_valid_o,
  output logic [IW-1:0]     flush_idx_o
);

  logic [DEPTH-1:0]  valid_v, spec_v, have_v, kill_v, resp_v, conf_v, fix_v, alloc_v, pop_v;
  logic [PA_W-1:0]   pa_a   [DEPTH];
  logic [DATA_W-1:0] data_a [DEPTH];
  logic [GEN_W-1:0]  gen_a  [DEPTH];

  logic [IW-1:0]    head, tail;
  logic             full, alloc_fire, pop, flush_evt, fix_evt;
  ver_out_e         outcome;
  logic             sel_valid, sel_spec, sel_have;
  logic [PA_W-1:0]  sel_pa;
  logic [GEN_W-1:0] sel_gen;

  // ---- selection of the entry named by the verification ----
  always_comb begin
    sel_valid = 1'b0;
    sel_spec  = 1'b0;
    sel_have  = 1'b0;
    sel_pa    = '0;
    sel_gen   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ver_idx_i == IW'(i)) begin
        sel_valid = valid_v[i];
        sel_spec  = spec_v[i];
        sel_have  = have_v[i];
        sel_pa    = pa_a[i];
        sel_gen   = gen_a[i];
      end
    end
  end

  stlq_verify #(.IW(IW), .PA_W(PA_W), .GEN_W(GEN_W)) u_verify (
    .clk           (clk),
    .rst_n         (rst_n),
    .ver_valid_i   (ver_valid_i),
    .ver_idx_i     (ver_idx_i),
    .ver_pa_i      (ver_pa_i),
    .sel_valid_i   (sel_valid),
    .sel_spec_i    (sel_spec),
    .sel_have_i    (sel_have),
    .sel_pa_i      (sel_pa),
    .sel_gen_i     (sel_gen),
    .outcome_o     (outcome),
    .flush_valid_o (flush_valid_o),
    .flush_idx_o   (flush_idx_o),
    .reis_valid_o  (reis_valid_o),
    .reis_idx_o    (reis_idx_o),
    .reis_pa_o     (reis_pa_o),
    .reis_gen_o    (reis_gen_o)
  );

  assign flush_evt = (outcome == VO_FLUSH);
  assign fix_evt   = (outcome == VO_REISSUE);

  // ---- pointers ----
  assign alloc_ready_o = !full && !flush_evt;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign cmt_valid_o   = ready_vec_o[head];
  assign pop           = cmt_valid_o && cmt_take_i;

  stlq_ptrs #(.DEPTH(DEPTH), .IW(IW)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_i     (alloc_fire),
    .pop_i       (pop),
    .flush_i     (flush_evt),
    .flush_idx_i (ver_idx_i),
    .head_o      (head),
    .tail_o      (tail),
    .full_o      (full)
  );

  // ---- entry array ----
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign alloc_v[i] = alloc_fire && (tail == IW'(i));
    assign pop_v[i]   = pop && (head == IW'(i));
    assign conf_v[i]  = (outcome == VO_CONFIRM) && (ver_idx_i == IW'(i));
    assign fix_v[i]   = fix_evt && (ver_idx_i == IW'(i));
    assign kill_v[i]  = flush_evt && valid_v[i] &&
                        (ring_dist(int'(head), i, DEPTH) >=
                         ring_dist(int'(head), int'(ver_idx_i), DEPTH));
    // stale-tag responses and responses racing a reissue are dropped
    assign resp_v[i]  = resp_valid_i && (resp_idx_i == IW'(i)) && valid_v[i] &&
                        !have_v[i] && (resp_gen_i == gen_a[i]) && !fix_v[i];
    assign ready_vec_o[i] = valid_v[i] && have_v[i] && !spec_v[i];

    stlq_entry #(.PA_W(PA_W), .DATA_W(DATA_W), .GEN_W(GEN_W)) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_v[i]),
      .alloc_spec_i (alloc_spec_i),
      .alloc_pa_i   (alloc_pa_i),
      .kill_i       (kill_v[i]),
      .pop_i        (pop_v[i]),
      .confirm_i    (conf_v[i]),
      .fix_i        (fix_v[i]),
      .fix_pa_i     (ver_pa_i),
      .resp_i       (resp_v[i]),
      .resp_data_i  (resp_data_i),
      .valid_o      (valid_v[i]),
      .spec_o       (spec_v[i]),
      .have_o       (have_v[i]),
      .pa_o         (pa_a[i]),
      .data_o       (data_a[i]),
      .gen_o        (gen_a[i])
    );
  end

  // ---- request and commit outputs ----
  assign mreq_valid_o = alloc_fire;
  assign mreq_idx_o   = tail;
  assign mreq_gen_o   = gen_a[tail] + GEN_W'(1);
  assign mreq_pa_o    = alloc_pa_i;
  assign cmt_idx_o    = head;
  assign cmt_pa_o     = pa_a[head];
  assign cmt_data_o   = data_a[head];

  // R5: a flush pulse finds the tail rewound to the flushed slot
  assert_flush_rewinds_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid_o |-> (tail == flush_idx_o))
    else $error("tail not rewound on flush");

  // R6: a reissue carries the tag the slot now holds
  assert_reissue_tag_current_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reis_valid_o |-> (reis_gen_o == gen_a[reis_idx_o]) && !flush_valid_o)
    else $error("reissue tag stale");

endmodule

// File: tb/spec_xlate_lsq_tb.sv
module spec_xlate_lsq_tb;
  localparam int D  = 6;
  localparam int IW = 3;
  localparam int PW = 12;
  localparam int DW = 16;
  localparam int GW = 2;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_spec = 0;
  logic [PW-1:0] alloc_pa = '0;
  logic alloc_ready, mreq_valid, reis_valid, cmt_valid, flush_valid;
  logic [IW-1:0] mreq_idx, reis_idx, cmt_idx, flush_idx;
  logic [GW-1:0] mreq_gen, reis_gen;
  logic [PW-1:0] mreq_pa, reis_pa, cmt_pa;
  logic resp_valid = 0;
  logic [IW-1:0] resp_idx = '0;
  logic [GW-1:0] resp_gen = '0;
  logic [DW-1:0] resp_data = '0, cmt_data;
  logic ver_valid = 0;
  logic [IW-1:0] ver_idx = '0;
  logic [PW-1:0] ver_pa = '0;
  logic [D-1:0] ready_vec;
  logic cmt_take = 0;

  always #5 clk = ~clk;

  spec_xlate_lsq #(.DEPTH(D), .PA_W(PW), .DATA_W(DW), .GEN_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_spec_i(alloc_spec), .alloc_pa_i(alloc_pa),
    .alloc_ready_o(alloc_ready),
    .mreq_valid_o(mreq_valid), .mreq_idx_o(mreq_idx), .mreq_gen_o(mreq_gen), .mreq_pa_o(mreq_pa),
    .reis_valid_o(reis_valid), .reis_idx_o(reis_idx), .reis_gen_o(reis_gen), .reis_pa_o(reis_pa),
    .resp_valid_i(resp_valid), .resp_idx_i(resp_idx), .resp_gen_i(resp_gen), .resp_data_i(resp_data),
    .ver_valid_i(ver_valid), .ver_idx_i(ver_idx), .ver_pa_i(ver_pa),
    .ready_vec_o(ready_vec),
    .cmt_valid_o(cmt_valid), .cmt_idx_o(cmt_idx), .cmt_pa_o(cmt_pa), .cmt_data_o(cmt_data),
    .cmt_take_i(cmt_take),
    .flush_valid_o(flush_valid), .flush_idx_o(flush_idx)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_tail = 0;
  int m_gen [D];
  int last_idx, last_gen;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(bit spec, logic [PW-1:0] pa);
    alloc_valid = 1; alloc_spec = spec; alloc_pa = pa;
    #1;
    last_idx = m_tail;
    last_gen = (m_gen[m_tail] + 1) % 4;
    chk("R1 mreq_valid", mreq_valid, 1);
    chk("R1 mreq_idx", mreq_idx, last_idx);
    chk("R1 mreq_gen", mreq_gen, last_gen);
    chk("R1 mreq_pa", mreq_pa, pa);
    m_gen[m_tail] = last_gen;
    m_tail = (m_tail + 1) % D;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_resp(int idx, int gen, logic [DW-1:0] data);
    resp_valid = 1; resp_idx = IW'(idx); resp_gen = GW'(gen); resp_data = data;
    @(negedge clk);
    resp_valid = 0;
  endtask

  task automatic do_ver(int idx, logic [PW-1:0] pa);
    ver_valid = 1; ver_idx = IW'(idx); ver_pa = pa;
    @(negedge clk);
    ver_valid = 0;
  endtask

  task automatic do_take();
    cmt_take = 1;
    @(negedge clk);
    cmt_take = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a, ga, b, gb, c;
    for (int i = 0; i < D; i++) m_gen[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 alloc_ready", alloc_ready, 1);
    chk("R10 cmt_valid", cmt_valid, 0);
    chk("R10 flush_valid", flush_valid, 0);
    chk("R10 reis_valid", reis_valid, 0);

    // R2 exact entry commits on data alone
    do_alloc(0, 12'h100);
    chk("R2 not ready before data", cmt_valid, 0);
    do_resp(last_idx, last_gen, 16'hAAAA);
    chk("R2 ready", cmt_valid, 1);
    chk("R2 data", cmt_data, 16'hAAAA);
    do_take();

    // R3/R4 data first, then matching verification
    do_alloc(1, 12'h210);
    do_resp(last_idx, last_gen, 16'h1234);
    chk("R3 held speculative", cmt_valid, 0);
    chk("R3 ready bit", ready_vec[last_idx], 0);
    do_ver(last_idx, 12'h210);
    chk("R4 ready after match", cmt_valid, 1);
    chk("R4 pa", cmt_pa, 12'h210);
    chk("R4 no flush", flush_valid, 0);
    chk("R4 no reissue", reis_valid, 0);
    do_take();

    // R4 verification first, then data
    do_alloc(1, 12'h300);
    do_ver(last_idx, 12'h300);
    chk("R4 no data yet", cmt_valid, 0);
    do_resp(last_idx, last_gen, 16'h3333);
    chk("R4 ready after data", cmt_valid, 1);
    do_take();

    // R6 mismatch before data -> reissue; R7 stale response dropped
    do_alloc(1, 12'h400);
    a = last_idx; ga = last_gen;
    do_ver(a, 12'h455);
    chk("R6 reissue", reis_valid, 1);
    chk("R6 reissue pa", reis_pa, 12'h455);
    chk("R6 reissue idx", reis_idx, a);
    chk("R6 reissue gen", reis_gen, (ga + 1) % 4);
    chk("R6 no flush", flush_valid, 0);
    m_gen[a] = (ga + 1) % 4;
    do_resp(a, ga, 16'hBAD0);
    chk("R7 stale dropped", cmt_valid, 0);
    do_resp(a, m_gen[a], 16'h600D);
    chk("R6 commit", cmt_valid, 1);
    chk("R6 data", cmt_data, 16'h600D);
    chk("R6 corrected pa", cmt_pa, 12'h455);
    do_take();

    // R5 mismatch after data -> flush younger entries
    do_alloc(1, 12'h500); a = last_idx; ga = last_gen;
    do_alloc(0, 12'h510); b = last_idx; gb = last_gen;
    do_alloc(0, 12'h520); c = last_idx;
    do_resp(a, ga, 16'h5555);
    do_resp(b, gb, 16'h5656);
    do_ver(a, 12'h777);
    chk("R5 flush", flush_valid, 1);
    chk("R5 flush idx", flush_idx, a);
    chk("R5 no reissue", reis_valid, 0);
    chk("R5 queue emptied", cmt_valid, 0);
    chk("R5 younger killed", ready_vec[b], 0);
    m_tail = a;
    do_alloc(0, 12'h5A0);
    chk("R5 next alloc reuses idx", last_idx, a);
    do_resp(b, gb, 16'hDEAD);
    do_resp(c, m_gen[c], 16'hDEAD);
    chk("R7 killed slot ignores data", ready_vec[b], 0);
    do_resp(last_idx, last_gen, 16'h5A5A);
    chk("R5 new entry commits", cmt_data, 16'h5A5A);
    chk("R5 new entry idx", cmt_idx, a);
    do_take();
    chk("R5 nothing after", cmt_valid, 0);

    // R8 in-order retire
    do_alloc(0, 12'h610); a = last_idx; ga = last_gen;
    do_alloc(0, 12'h620); b = last_idx; gb = last_gen;
    do_resp(b, gb, 16'h0B0B);
    chk("R8 younger waits", cmt_valid, 0);
    chk("R8 younger ready bit", ready_vec[b], 1);
    do_resp(a, ga, 16'h0A0A);
    chk("R8 head first", cmt_idx, a);
    do_take();
    chk("R8 then younger", cmt_idx, b);
    chk("R8 younger data", cmt_data, 16'h0B0B);
    do_take();

    // R9 verification on exact or empty entries
    do_alloc(0, 12'h111); a = last_idx; ga = last_gen;
    do_ver(a, 12'h999);
    chk("R9 no flush", flush_valid, 0);
    chk("R9 no reissue", reis_valid, 0);
    do_ver((m_tail + 2) % D, 12'h999);
    chk("R9 empty no flush", flush_valid, 0);
    chk("R9 empty no reissue", reis_valid, 0);
    do_resp(a, ga, 16'h9999);
    chk("R9 pa unchanged", cmt_pa, 12'h111);
    do_take();

    // sweep: every ordering in every slot, with wrap and full
    for (int r = 0; r < 4; r++) begin
      int ix [D];
      int gx [D];
      logic [PW-1:0] px [D];
      logic [PW-1:0] ex [D];
      logic [DW-1:0] dx [D];
      for (int k = 0; k < D; k++) begin
        chk("R1 ready before full", alloc_ready, 1);
        px[k] = PW'(r * 64 + k * 5 + 1);
        do_alloc(((r + k) % 4) != 0, px[k]);
        ix[k] = last_idx; gx[k] = last_gen;
      end
      chk("R1 full blocks alloc", alloc_ready, 0);
      for (int k = 0; k < D; k++) begin
        dx[k] = DW'(r * 256 + k * 3 + 7);
        ex[k] = px[k];
        case ((r + k) % 4)
          0: do_resp(ix[k], gx[k], dx[k]);
          1: begin do_ver(ix[k], px[k]); do_resp(ix[k], gx[k], dx[k]); end
          2: begin
               do_resp(ix[k], gx[k], dx[k]);
               chk("R3 sweep held", ready_vec[ix[k]], 0);
               do_ver(ix[k], px[k]);
             end
          default: begin
               ex[k] = px[k] ^ 12'h800;
               do_ver(ix[k], ex[k]);
               chk("R6 sweep reissue", reis_valid, 1);
               chk("R6 sweep gen", reis_gen, (gx[k] + 1) % 4);
               m_gen[ix[k]] = (gx[k] + 1) % 4;
               do_resp(ix[k], gx[k], 16'hFFFF);
               chk("R7 sweep stale", ready_vec[ix[k]], 0);
               do_resp(ix[k], m_gen[ix[k]], dx[k]);
             end
        endcase
        chk("R4 sweep ready", ready_vec[ix[k]], 1);
      end
      for (int k = 0; k < D; k++) begin
        chk("R8 sweep valid", cmt_valid, 1);
        chk("R8 sweep idx", cmt_idx, ix[k]);
        chk("R8 sweep pa", cmt_pa, ex[k]);
        chk("R8 sweep data", cmt_data, dx[k]);
        do_take();
      end
      chk("R8 sweep drained", cmt_valid, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule